// File: doc/BRIEF.md
# Source-Routed Port Stripper

This block is the routing stage of a switch in a network that routes by source. The sender writes into the first flit of every packet the whole path: one output port number for each switch the packet will cross, in the order it will cross them. A switch does not work out a route. It reads the port number at the front of that list, uses it as the output select for the whole packet, and removes it. The next switch then finds its own entry at the front, so the list gets one entry shorter at every hop.

Packets arrive as a stream of fixed-width flits with a last marker. The first flit (the head) carries a hop-count field in its top bits and the route field directly below it. The current entry sits in the top bits of the route field. The bits below the route field are payload and pass through untouched. A head whose hop count is already zero has reached its destination switch. It goes to the local port and is not changed. Both sides use valid/ready handshaking. A single register stage between the two sides keeps full throughput and holds its contents while the downstream side is not ready.

Top module: `psr_port_stripper`

## Requirements
- R1: The head flit layout is as follows. The hop count occupies bits [FLIT_W-1 : FLIT_W-CNT_W], where CNT_W = clog2(MAX_HOPS+1). The route field of MAX_HOPS*PORT_W bits lies directly below the hop count. When the count is nonzero, out_port for the packet equals the top PORT_W bits of the route field.
- R2: When the count is nonzero, the forwarded head carries the count minus one and the route field shifted up by PORT_W bits with zeros filled in at the bottom. Its payload bits below the route field are unchanged.
- R3: A head whose hop count is zero is sent with out_port = LOCAL_PORT, and its data is forwarded bit for bit.
- R4: Flits after the head are forwarded unchanged, even if their contents look like a header. Every flit of a packet, up to and including the flit marked last, carries the same out_port as the head.
- R5: The flit accepted after a flit marked last is treated as a new head.
- R6: While out_valid is high and out_ready is low, out_data, out_last and out_port hold their values and in_ready is low. No flit is lost or duplicated.
- R7: After reset, out_valid is low and in_ready is high.
- R8: Whenever out_ready is high, in_ready is high, so one flit per cycle passes when neither side stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Block can take a flit this cycle |
| in_data | input | FLIT_W | Upstream flit |
| in_last | input | 1 | Upstream flit ends its packet |
| out_valid | output | 1 | Downstream flit valid |
| out_ready | input | 1 | Downstream can take a flit |
| out_data | output | FLIT_W | Forwarded flit (head rewritten) |
| out_last | output | 1 | Forwarded flit ends its packet |
| out_port | output | PORT_W | Output port select for this flit |

## Verification
The bench builds the block with FLIT_W=28, PORT_W=2, MAX_HOPS=5 and LOCAL_PORT=3. This gives a 3-bit count, a 10-bit route field and 15 payload bits. With these values, a full five-entry route, a zero-count head, and a local port number that is also a legal route entry are all cheap to reach. The bench sends single-flit packets, packets whose body flits mimic header bits, and back-to-back packets. It runs them first with no stalls on either side and then with random stalls on both sides. The bench checks every forwarded flit and every stalled cycle against a behavioural model.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic {
    PH_SEEK_HEAD = 1'b0,
    PH_IN_BODY   = 1'b1
  } pkt_phase_e;
endpackage

// File: rtl/psr_head_rewrite.sv
module psr_head_rewrite #(
  parameter int FLIT_W     = 32,
  parameter int PORT_W     = 3,
  parameter int MAX_HOPS   = 6,
  parameter int LOCAL_PORT = 7
) (
  input  logic [FLIT_W-1:0]                 flit_i,
  output logic [FLIT_W-1:0]                 flit_o,
  output logic [PORT_W-1:0]                 port_o,
  output logic [$clog2(MAX_HOPS+1)-1:0]     cnt_o,
  output logic                              at_dest_o
);
  localparam int CNT_W     = $clog2(MAX_HOPS+1);
  localparam int ROUTE_W   = MAX_HOPS * PORT_W;
  localparam int CNT_LSB   = FLIT_W - CNT_W;
  localparam int ROUTE_LSB = CNT_LSB - ROUTE_W;

  function automatic logic [ROUTE_W-1:0] drop_front(input logic [ROUTE_W-1:0] r);
    return {r[ROUTE_W-PORT_W-1:0], {PORT_W{1'b0}}};
  endfunction

  function automatic logic [PORT_W-1:0] front_entry(input logic [ROUTE_W-1:0] r);
    return r[ROUTE_W-1 -: PORT_W];
  endfunction

  function automatic logic [CNT_W-1:0] one_less(input logic [CNT_W-1:0] c);
    return c - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0]   cnt;
  logic [ROUTE_W-1:0] route;

  assign cnt       = flit_i[FLIT_W-1 -: CNT_W];
  assign route     = flit_i[CNT_LSB-1 -: ROUTE_W];
  assign cnt_o     = cnt;
  assign at_dest_o = (cnt == '0);

  always_comb begin
    if (at_dest_o) begin
      port_o = PORT_W'(LOCAL_PORT);
      flit_o = flit_i;
    end else begin
      port_o = front_entry(route);
      flit_o = {one_less(cnt), drop_front(route), flit_i[ROUTE_LSB-1:0]};
    end
  end
endmodule

// File: rtl/psr_pkt_track.sv
module psr_pkt_track
  import psr_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              last_i,
  input  logic [PORT_W-1:0] head_port_i,
  output logic              is_head_o,
  output logic [PORT_W-1:0] sel_port_o
);
  pkt_phase_e        phase_q;
  logic [PORT_W-1:0] hold_port_q;

  assign is_head_o  = (phase_q == PH_SEEK_HEAD);
  assign sel_port_o = is_head_o ? head_port_i : hold_port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_SEEK_HEAD;
      hold_port_q <= '0;
    end else if (accept_i) begin
      if (is_head_o) hold_port_q <= head_port_i;
      phase_q <= last_i ? PH_SEEK_HEAD : PH_IN_BODY;
    end
  end

  // R5: a packet's last flit re-arms head detection
  assert_new_head_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && last_i) |=> is_head_o);

  // R4: port used for a body flit matches the port taken from its head
  assert_body_port_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && is_head_o && !last_i) |=> (sel_port_o == $past(head_port_i) || is_head_o));
endmodule

// File: rtl/psr_out_stage.sv
module psr_out_stage #(
  parameter int FLIT_W = 32,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_last,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_last,
  output logic [PORT_W-1:0] out_port
);
  logic              full_q;
  logic [FLIT_W-1:0] data_q;
  logic              last_q;
  logic [PORT_W-1:0] port_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;
  assign out_last  = last_q;
  assign out_port  = port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      last_q <= 1'b0;
      port_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) begin
        data_q <= in_data;
        last_q <= in_last;
        port_q <= in_port;
      end
    end
  end

  // R6: stalled output is held steady
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_port)));

  // R6: no new flit is taken while the held one is stuck
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: downstream ready always opens the input
  assert_full_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

// File: rtl/psr_port_stripper.sv
module psr_port_stripper #(
  parameter int FLIT_W     = 32,
  parameter int PORT_W     = 3,
  parameter int MAX_HOPS   = 6,
  parameter int LOCAL_PORT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_last,
  output logic [PORT_W-1:0] out_port
);
  localparam int CNT_W = $clog2(MAX_HOPS+1);

  logic [FLIT_W-1:0] head_flit;
  logic [PORT_W-1:0] head_port;
  logic [CNT_W-1:0]  head_cnt;
  logic              head_at_dest;
  logic              is_head;
  logic [PORT_W-1:0] sel_port;
  logic [FLIT_W-1:0] fwd_data;
  logic              accept;
  logic              head_fire;

  psr_head_rewrite #(
    .FLIT_W(FLIT_W), .PORT_W(PORT_W), .MAX_HOPS(MAX_HOPS), .LOCAL_PORT(LOCAL_PORT)
  ) u_rewrite (
    .flit_i(in_data), .flit_o(head_flit), .port_o(head_port),
    .cnt_o(head_cnt), .at_dest_o(head_at_dest)
  );

  psr_pkt_track #(.PORT_W(PORT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .last_i(in_last),
    .head_port_i(head_port), .is_head_o(is_head), .sel_port_o(sel_port)
  );

  assign accept    = in_valid && in_ready;
  assign head_fire = accept && is_head;
  assign fwd_data  = is_head ? head_flit : in_data;

  psr_out_stage #(.FLIT_W(FLIT_W), .PORT_W(PORT_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(fwd_data),
    .in_last(in_last), .in_port(sel_port),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_port(out_port)
  );

  // R2: stripped head leaves with a count one lower
  assert_count_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (head_fire && !head_at_dest) |=> (out_valid && out_data[FLIT_W-1 -: CNT_W] == $past(head_cnt) - 1'b1));

  // R1: stripped head steers to its front route entry
  assert_front_entry_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (head_fire && !head_at_dest) |=> (out_port == $past(in_data[FLIT_W-CNT_W-1 -: PORT_W])));

  // R3: arrived packet goes local, head unchanged
  assert_local_delivery_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_fire && head_at_dest) |=> (out_port == PORT_W'(LOCAL_PORT) && out_data == $past(in_data)));

  // R4: port never changes between flits of one packet
  assert_port_steady_in_packet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_port == $past(out_port)));
endmodule

// File: tb/psr_port_stripper_tb_top.sv
`timescale 1ns/1ps
module psr_port_stripper_tb_top;
  localparam int FW = 28, PW = 2, MH = 5, LP = 3;
  localparam int CW = 3, RW = MH * PW, CL = FW - CW, RL = CL - RW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [FW-1:0] in_data, out_data;
  logic [PW-1:0] out_port;

  psr_port_stripper #(.FLIT_W(FW), .PORT_W(PW), .MAX_HOPS(MH), .LOCAL_PORT(LP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_port(out_port));

  typedef struct { logic [FW-1:0] d; logic l; } flit_t;
  typedef struct { logic [FW-1:0] d; logic l; logic [PW-1:0] p; string tag; } exp_t;
  flit_t stim_q[$];
  exp_t  exp_q[$];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_pkt(input int cnt, input int route, input int nbody);
    flit_t f;
    longint h;
    h = (longint'(cnt) << CL) | (longint'(route) << RL) | longint'($urandom % (1 << RL));
    f.d = h[FW-1:0];
    f.l = (nbody == 0);
    stim_q.push_back(f);
    for (int i = 0; i < nbody; i++) begin
      f.d = FW'($urandom);
      f.l = (i == nbody - 1);
      stim_q.push_back(f);
    end
  endtask

  bit            m_head = 1'b1;
  int            m_port = 0;
  bit            bp_on = 1'b0;
  bit            have = 1'b0;
  flit_t         cf;
  bit            stall_pend = 1'b0;
  logic [FW-1:0] sd;
  logic          sl;
  logic [PW-1:0] sp;
  int            pkt_no = 0;

  task automatic model_push(input flit_t f);
    exp_t   e;
    longint x, cnt, route, nr;
    x = longint'(f.d);
    e.l = f.l;
    if (m_head) begin
      cnt   = x >> CL;
      route = (x >> RL) % (longint'(1) << RW);
      if (cnt == 0) begin
        m_port = LP;
        e.d = f.d;
        e.tag = "R3";
      end else begin
        m_port = int'(route / (longint'(1) << (RW - PW)));
        nr = (route * (longint'(1) << PW)) % (longint'(1) << RW);
        x = ((cnt - 1) << CL) + (nr << RL) + (x % (longint'(1) << RL));
        e.d = x[FW-1:0];
        e.tag = (pkt_no == 0) ? "R1 R2" : "R1 R2 R5";
      end
      pkt_no++;
    end else begin
      e.d = f.d;
      e.tag = "R4";
    end
    e.p = PW'(m_port);
    m_head = f.l;
    exp_q.push_back(e);
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    if (stall_pend)
      chk(out_valid && out_data == sd && out_last == sl && out_port == sp,
          "R6", "held output", longint'(out_data), longint'(sd));
    if (!have && stim_q.size() > 0) begin
      cf = stim_q.pop_front();
      have = 1'b1;
    end
    in_valid  = have && (!bp_on || ($urandom % 4) != 0);
    in_data   = have ? cf.d : '0;
    in_last   = have ? cf.l : 1'b0;
    out_ready = !bp_on || ($urandom % 3) != 0;
    #1;
    if (out_ready) chk(in_ready, "R8", "in_ready with out_ready", longint'(in_ready), 1);
    if (out_valid && !out_ready) chk(!in_ready, "R6", "in_ready while stalled", longint'(in_ready), 0);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "extra flit", longint'(out_data), 0);
      end else begin
        e = exp_q.pop_front();
        chk(out_data == e.d, e.tag, "data", longint'(out_data), longint'(e.d));
        chk(out_port == e.p && out_last == e.l, e.tag, "port/last",
            longint'({out_port, out_last}), longint'({e.p, e.l}));
      end
    end
    stall_pend = out_valid && !out_ready;
    sd = out_data; sl = out_last; sp = out_port;
    if (in_valid && in_ready) begin
      model_push(cf);
      have = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R7", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready, "R7", "in_ready after reset", longint'(in_ready), 1);
    // directed packets: two hops, arrived, full route single flit, one hop
    add_pkt(2, 10'b10_01_11_00_01, 3);
    add_pkt(0, 10'b11_11_11_11_11, 2);
    add_pkt(5, 10'b01_10_11_00_10, 0);
    add_pkt(1, 10'b11_00_00_00_00, 1);
    add_pkt(0, 0, 0);
    while (stim_q.size() > 0 || have) step();
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++) add_pkt($urandom % (MH + 1), $urandom % (1 << RW), $urandom % 4);
    while (stim_q.size() > 0 || have) step();
    for (int i = 0; i < 200 && (exp_q.size() > 0 || out_valid); i++) step();
    chk(exp_q.size() == 0, "R6", "flits lost", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule